// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block brings up an external bridge that turns parallel RGB pixel data into a serial display link. After a `start` pulse it pulses the bridge's active-low reset. If the host can read registers back, it checks the bridge's identity. It then programs the video timing, pixel format, lane count, link configuration, PLL and low-power clock divider. It waits for the PLL to lock and sends the panel its exit-sleep and display-on commands, each followed by a programmable pause. Last, it switches the data lanes to high speed and enables the video pipeline.

Every register access leaves the block as one request on a simple access port. A separate serial-link engine performs the access and answers with a one-cycle completion. The block does no PLL arithmetic: the PLL word and the low-power divider come in as inputs. All waits are counted in system clocks, using a ticks-per-microsecond parameter.

Top module: `disp_bridge_bringup`

## Requirements
- R1: After reset, `bridge_rst_n` is 1 and `acc_req`, `busy`, `done` and `error` are all 0.
- R2: A `start` pulse drives `bridge_rst_n` low for exactly RESET_US*TICKS_PER_US clocks. It then holds high for the same count before the first access request. No request is made while the bridge reset is low.
- R3: With `readback_en` high, the first two accesses are reads (`acc_we`=0), first of address 0xB0 and then of 0xB7. The returned data must be 0x2828 and then 0x0301. Otherwise `error` rises and no further request is made.
- R4: With `readback_en` low, no read is issued and the first access is the write to 0xB1.
- R5: The timing writes go in this order: 0xB1 = {vsync,hsync}; 0xB2 = {vsync+vback, hsync+hback}, each byte truncated to 8 bits; 0xB3 = {vfront,hfront}; 0xB4 = width; 0xB5 = height.
- R6: Address 0xB6 receives 0x0008 ORed with a format code. The code is 0 for 16 bpp, 1 for 18 bpp packed, 2 for 18 bpp with `loose_18` set, and 3 for 24 bpp. Address 0xDE then receives `lanes`-1.
- R7: A `color_bpp` other than 16, 18 or 24 makes `error` rise on the clock after `start`. The bridge reset does not pulse and no access is made.
- R8: Next, 0xB7 receives the command-phase configuration 0x0342, or 0x0362 when `pclk_ref` is high (bit 5 selects the pixel clock as PLL reference).
- R9: Four writes follow in order: `pll_word` to 0xBA, 0 to 0xB8, (`lp_div`-1) & 0x3F to 0xBB, and 1 to 0xB9.
- R10: After the 0xB9 write completes, `acc_req` stays low for exactly LOCK_US*TICKS_PER_US clocks before the next request.
- R11: Each of two commands is sent as 1 written to 0xBC and then the command byte written to 0xBF: first 0x11, then 0x29. After each command's last write, `acc_req` stays low for max(1, delay_us*TICKS_PER_US) clocks. The delay comes from `sleep_exit_us` for the first command and `disp_on_us` for the second.
- R12: The final write puts the command-phase configuration ORed with 0x0009 into 0xB7. `done` then rises with `acc_req` low. A new `start` from the done or error state reruns the whole sequence.
- R13: Once raised, a request keeps its address, direction and data unchanged until the cycle in which `acc_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| start | input | 1 | Begin the bring-up sequence (accepted when not busy) |
| readback_en | input | 1 | Read path exists; enables the identity check |
| pclk_ref | input | 1 | Pixel clock serves as PLL reference |
| color_bpp | input | 6 | Colour depth in bits per pixel (16, 18 or 24) |
| loose_18 | input | 1 | Select the loosely packed 18 bpp format |
| lanes | input | 3 | Number of data lanes |
| hsync_w | input | 8 | Horizontal sync width |
| hback | input | 8 | Horizontal back porch |
| hfront | input | 8 | Horizontal front porch |
| vsync_w | input | 8 | Vertical sync width |
| vback | input | 8 | Vertical back porch |
| vfront | input | 8 | Vertical front porch |
| width | input | 16 | Active pixels per line |
| height | input | 16 | Active lines per frame |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lp_div | input | 8 | Low-power clock divider |
| sleep_exit_us | input | DLY_W | Pause after the exit-sleep command, in microseconds |
| disp_on_us | input | DLY_W | Pause after the display-on command, in microseconds |
| bridge_rst_n | output | 1 | Active-low reset to the bridge |
| acc_req | output | 1 | Register access request |
| acc_we | output | 1 | Request is a write (1) or read (0) |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 16 | Write data |
| acc_done | input | 1 | One-cycle completion of the current request |
| acc_rdata | input | 16 | Read data, valid with `acc_done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence aborted |

## Verification
The assertions rely on two things about the environment. All configuration inputs are held steady from `start` until `done` or `error`, so the write data of a pending request cannot move. `acc_done` is pulsed only while a request is pending. The bench loads each configuration before pulsing `start` and leaves it untouched until the run ends. Its responder asserts completion only for a request it has already captured, after a fixed latency of a few clocks.

// File: rtl/disp_bridge_bringup.sv
module disp_bridge_bringup #(
  parameter int TICKS_PER_US = 100,
  parameter int RESET_US     = 10000,
  parameter int LOCK_US      = 500,
  parameter int DLY_W        = 16,
  parameter int TMR_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             readback_en,
  input  logic             pclk_ref,
  input  logic [5:0]       color_bpp,
  input  logic             loose_18,
  input  logic [2:0]       lanes,
  input  logic [7:0]       hsync_w,
  input  logic [7:0]       hback,
  input  logic [7:0]       hfront,
  input  logic [7:0]       vsync_w,
  input  logic [7:0]       vback,
  input  logic [7:0]       vfront,
  input  logic [15:0]      width,
  input  logic [15:0]      height,
  input  logic [15:0]      pll_word,
  input  logic [7:0]       lp_div,
  input  logic [DLY_W-1:0] sleep_exit_us,
  input  logic [DLY_W-1:0] disp_on_us,
  output logic             bridge_rst_n,
  output logic             acc_req,
  output logic             acc_we,
  output logic [7:0]       acc_addr,
  output logic [15:0]      acc_wdata,
  input  logic             acc_done,
  input  logic [15:0]      acc_rdata,
  output logic             busy,
  output logic             done,
  output logic             error
);

  localparam logic [TMR_W-1:0] RST_LOAD  = TMR_W'(RESET_US * TICKS_PER_US - 1);
  localparam logic [TMR_W-1:0] LOCK_LOAD = TMR_W'(LOCK_US * TICKS_PER_US - 1);

  localparam logic [4:0] S_ID    = 5'd0;
  localparam logic [4:0] S_FIRST = 5'd2;
  localparam logic [4:0] S_PLLON = 5'd13;
  localparam logic [4:0] S_CMD1  = 5'd15;
  localparam logic [4:0] S_CMD2  = 5'd17;
  localparam logic [4:0] S_LAST  = 5'd18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_LO, ST_RST_HI, ST_ACC, ST_WAIT, ST_DONE, ST_ERR
  } st_e;

  st_e              st;
  logic [4:0]       step;
  logic [TMR_W-1:0] tmr;
  logic [1:0]       fmt;
  logic             fmt_ok;
  logic [15:0]      cfg_cmd;
  logic [15:0]      exp_rd;
  logic [7:0]       vtot, htot, lpm1;
  logic [2:0]       lanes_m1;

  function automatic logic [TMR_W-1:0] ticks_load(input logic [DLY_W-1:0] us);
    logic [TMR_W-1:0] t;
    t = TMR_W'(us) * TMR_W'(TICKS_PER_US);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign fmt_ok = (color_bpp == 6'd16) || (color_bpp == 6'd18) || (color_bpp == 6'd24);
  assign fmt    = (color_bpp == 6'd16) ? 2'd0 :
                  (color_bpp == 6'd24) ? 2'd3 :
                  loose_18             ? 2'd2 : 2'd1;
  assign cfg_cmd  = pclk_ref ? 16'h0362 : 16'h0342;
  assign vtot     = vsync_w + vback;
  assign htot     = hsync_w + hback;
  assign lpm1     = lp_div - 8'd1;
  assign lanes_m1 = lanes - 3'd1;

  assign bridge_rst_n = (st != ST_RST_LO);
  assign acc_req      = (st == ST_ACC);
  assign busy         = (st == ST_RST_LO) || (st == ST_RST_HI) || (st == ST_ACC) || (st == ST_WAIT);
  assign done         = (st == ST_DONE);
  assign error        = (st == ST_ERR);

  always_comb begin
    acc_we    = 1'b1;
    acc_addr  = 8'h00;
    acc_wdata = 16'h0000;
    exp_rd    = 16'h0000;
    case (step)
      5'd0:  begin acc_we = 1'b0; acc_addr = 8'hB0; exp_rd = 16'h2828; end
      5'd1:  begin acc_we = 1'b0; acc_addr = 8'hB7; exp_rd = 16'h0301; end
      5'd2:  begin acc_addr = 8'hB1; acc_wdata = {vsync_w, hsync_w}; end
      5'd3:  begin acc_addr = 8'hB2; acc_wdata = {vtot, htot}; end
      5'd4:  begin acc_addr = 8'hB3; acc_wdata = {vfront, hfront}; end
      5'd5:  begin acc_addr = 8'hB4; acc_wdata = width; end
      5'd6:  begin acc_addr = 8'hB5; acc_wdata = height; end
      5'd7:  begin acc_addr = 8'hB6; acc_wdata = {12'h000, 2'b10, fmt}; end
      5'd8:  begin acc_addr = 8'hDE; acc_wdata = {13'd0, lanes_m1}; end
      5'd9:  begin acc_addr = 8'hB7; acc_wdata = cfg_cmd; end
      5'd10: begin acc_addr = 8'hBA; acc_wdata = pll_word; end
      5'd11: begin acc_addr = 8'hB8; acc_wdata = 16'h0000; end
      5'd12: begin acc_addr = 8'hBB; acc_wdata = {10'd0, lpm1[5:0]}; end
      5'd13: begin acc_addr = 8'hB9; acc_wdata = 16'h0001; end
      5'd14: begin acc_addr = 8'hBC; acc_wdata = 16'h0001; end
      5'd15: begin acc_addr = 8'hBF; acc_wdata = 16'h0011; end
      5'd16: begin acc_addr = 8'hBC; acc_wdata = 16'h0001; end
      5'd17: begin acc_addr = 8'hBF; acc_wdata = 16'h0029; end
      5'd18: begin acc_addr = 8'hB7; acc_wdata = cfg_cmd | 16'h0009; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= S_ID;
      tmr  <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE, ST_ERR:
          if (start) begin
            if (!fmt_ok) st <= ST_ERR;
            else begin
              st  <= ST_RST_LO;
              tmr <= RST_LOAD;
            end
          end
        ST_RST_LO:
          if (tmr == '0) begin
            st  <= ST_RST_HI;
            tmr <= RST_LOAD;
          end else tmr <= tmr - 1'b1;
        ST_RST_HI:
          if (tmr == '0) begin
            st   <= ST_ACC;
            step <= readback_en ? S_ID : S_FIRST;
          end else tmr <= tmr - 1'b1;
        ST_ACC:
          if (acc_done) begin
            if (!acc_we && acc_rdata != exp_rd) st <= ST_ERR;
            else begin
              step <= step + 5'd1;
              case (step)
                S_PLLON: begin st <= ST_WAIT; tmr <= LOCK_LOAD; end
                S_CMD1:  begin st <= ST_WAIT; tmr <= ticks_load(sleep_exit_us); end
                S_CMD2:  begin st <= ST_WAIT; tmr <= ticks_load(disp_on_us); end
                S_LAST:  st <= ST_DONE;
                default: ;
              endcase
            end
          end
        ST_WAIT:
          if (tmr == '0) st <= ST_ACC;
          else tmr <= tmr - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> (!acc_req && busy));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!acc_req && bridge_rst_n && !done));

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_done) |=> (acc_req && $stable(acc_addr) && $stable(acc_we) && $stable(acc_wdata)));

  // R10
  lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_done && acc_we && acc_addr == 8'hB9) |=> !acc_req);

  // R3
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we) |-> (acc_addr == 8'hB0 || acc_addr == 8'hB7));

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!acc_req && bridge_rst_n && !busy));

endmodule

// File: tb/disp_bridge_bringup_bench.sv
module disp_bridge_bringup_bench;
  localparam int TPU = 2, RUS = 10, LUS = 5;
  localparam int RST_T = RUS * TPU, LOCK_T = LUS * TPU;

  logic clk = 0, rst_n = 0, start = 0, readback_en = 0, pclk_ref = 0, loose_18 = 0;
  logic [5:0] color_bpp = 6'd24;
  logic [2:0] lanes = 3'd4;
  logic [7:0] hsync_w = 0, hback = 0, hfront = 0, vsync_w = 0, vback = 0, vfront = 0, lp_div = 1;
  logic [15:0] width = 0, height = 0, pll_word = 0;
  logic [15:0] sleep_exit_us = 0, disp_on_us = 0;
  logic bridge_rst_n, acc_req, acc_we, busy, done, error;
  logic [7:0] acc_addr;
  logic [15:0] acc_wdata;
  logic acc_done = 0;
  logic [15:0] acc_rdata = 0;
  logic [15:0] id_resp = 16'h2828, cfg_resp = 16'h0301;

  int vectors = 0, fails = 0;

  typedef struct {
    bit        we;
    bit [7:0]  addr;
    bit [15:0] data;
    int        gap;
    bit        first;
    string     tag;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  disp_bridge_bringup #(.TICKS_PER_US(TPU), .RESET_US(RUS), .LOCK_US(LUS)) u_disp_bridge_bringup (
    .clk(clk), .rst_n(rst_n), .start(start), .readback_en(readback_en), .pclk_ref(pclk_ref),
    .color_bpp(color_bpp), .loose_18(loose_18), .lanes(lanes),
    .hsync_w(hsync_w), .hback(hback), .hfront(hfront),
    .vsync_w(vsync_w), .vback(vback), .vfront(vfront),
    .width(width), .height(height), .pll_word(pll_word), .lp_div(lp_div),
    .sleep_exit_us(sleep_exit_us), .disp_on_us(disp_on_us),
    .bridge_rst_n(bridge_rst_n), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .busy(busy), .done(done), .error(error));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit we, input bit [7:0] a, input bit [15:0] d, input int gap, input bit first, input string tag);
    exp_t e;
    e.we = we; e.addr = a; e.data = d; e.gap = gap; e.first = first; e.tag = tag;
    expq.push_back(e);
  endtask

  // Monitor and responder: pops the expected item for every new request.
  int gap = 0, rlow = 0, lat = 0;
  bit in_tx = 0;
  always @(negedge clk) begin
    acc_done = 1'b0;
    if (rst_n) begin
      if (start) begin gap = 0; rlow = 0; end
      if (!acc_req) gap++;
      if (!bridge_rst_n) rlow++;
      if (acc_req) begin
        if (!in_tx) begin
          in_tx = 1; lat = 0;
          if (expq.size() == 0) chk(0, "R3/R7", "unexpected request addr", int'(acc_addr), 0);
          else begin
            exp_t e;
            e = expq.pop_front();
            chk(acc_we === e.we && acc_addr === e.addr, e.tag, "addr/we", int'({acc_we, acc_addr}), int'({e.we, e.addr}));
            if (e.we) chk(acc_wdata === e.data, e.tag, "wdata", int'(acc_wdata), int'(e.data));
            if (e.gap >= 0) chk(gap == e.gap, e.tag, "idle cycles before request", gap, e.gap);
            if (e.first) chk(rlow == RST_T, "R2", "bridge reset low cycles", rlow, RST_T);
          end
          gap = 0;
        end else lat++;
        if (lat == 2) begin
          acc_done = 1'b1;
          acc_rdata = (acc_addr == 8'hB0) ? id_resp : (acc_addr == 8'hB7) ? cfg_resp : 16'hDEAD;
          in_tx = 0;
        end
      end
    end
  end

  function automatic int dly(input int us);
    return (us * TPU == 0) ? 1 : us * TPU;
  endfunction

  // Expected sequence from the timing writes onward (R5, R6, R8, R9, R10, R11, R12).
  task automatic push_body(input bit first);
    bit [1:0] f;
    bit [15:0] cfg;
    f = (color_bpp == 16) ? 2'd0 : (color_bpp == 24) ? 2'd3 : (loose_18 ? 2'd2 : 2'd1);
    cfg = pclk_ref ? 16'h0362 : 16'h0342;
    push(1, 8'hB1, {vsync_w, hsync_w}, first ? 2 * RST_T : 0, first, "R5");
    push(1, 8'hB2, {8'(vsync_w + vback), 8'(hsync_w + hback)}, 0, 0, "R5");
    push(1, 8'hB3, {vfront, hfront}, 0, 0, "R5");
    push(1, 8'hB4, width, 0, 0, "R5");
    push(1, 8'hB5, height, 0, 0, "R5");
    push(1, 8'hB6, 16'h0008 | 16'(f), 0, 0, "R6");
    push(1, 8'hDE, 16'(lanes - 3'd1), 0, 0, "R6");
    push(1, 8'hB7, cfg, 0, 0, "R8");
    push(1, 8'hBA, pll_word, 0, 0, "R9");
    push(1, 8'hB8, 16'h0000, 0, 0, "R9");
    push(1, 8'hBB, 16'((lp_div - 8'd1) & 8'h3F), 0, 0, "R9");
    push(1, 8'hB9, 16'h0001, 0, 0, "R9");
    push(1, 8'hBC, 16'h0001, LOCK_T, 0, "R10");
    push(1, 8'hBF, 16'h0011, 0, 0, "R11");
    push(1, 8'hBC, 16'h0001, dly(int'(sleep_exit_us)), 0, "R11");
    push(1, 8'hBF, 16'h0029, 0, 0, "R11");
    push(1, 8'hB7, cfg | 16'h0009, dly(int'(disp_on_us)), 0, "R12");
  endtask

  task automatic run(input bit exp_ok, input string tag);
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
    while (!(done || error)) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(done == exp_ok && error == !exp_ok, tag, "done/error", int'({done, error}), int'({exp_ok, !exp_ok}));
    chk(expq.size() == 0, tag, "requests missing", expq.size(), 0);
    chk(!acc_req && bridge_rst_n && !busy, tag, "quiet after end", int'({acc_req, bridge_rst_n, busy}), 3'b010);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(bridge_rst_n && !acc_req && !busy && !done && !error, "R1", "reset outputs",
        int'({bridge_rst_n, acc_req, busy, done, error}), 5'b10000);

    // Case A: identity check, 24 bpp, tx reference (R3)
    #1 readback_en = 1; pclk_ref = 0; color_bpp = 24; lanes = 4;
    hsync_w = 8'd10; hback = 8'd20; hfront = 8'd30; vsync_w = 8'd2; vback = 8'd4; vfront = 8'd6;
    width = 16'd800; height = 16'd480; pll_word = 16'h4A2C; lp_div = 8'd5;
    sleep_exit_us = 16'd3; disp_on_us = 16'd2;
    push(0, 8'hB0, 0, 2 * RST_T, 1, "R3");
    push(0, 8'hB7, 0, 0, 0, "R3");
    push_body(0);
    run(1, "R12");

    // Case B: no read-back, loose 18 bpp, pixel clock reference, zero sleep delay (R4)
    #1 readback_en = 0; pclk_ref = 1; color_bpp = 18; loose_18 = 1; lanes = 2;
    hsync_w = 8'd200; hback = 8'd100; vsync_w = 8'd250; vback = 8'd9; lp_div = 8'd0;
    sleep_exit_us = 16'd0; disp_on_us = 16'd1;
    push_body(1);
    run(1, "R4");

    // Case C: packed 18 bpp and 16 bpp, single lane
    #1 loose_18 = 0; lanes = 1; pclk_ref = 0; lp_div = 8'd70;
    push_body(1);
    run(1, "R6");
    #1 color_bpp = 16;
    push_body(1);
    run(1, "R6");

    // Case D: identity mismatch (R3)
    #1 readback_en = 1; id_resp = 16'h2827;
    push(0, 8'hB0, 0, 2 * RST_T, 1, "R3");
    run(0, "R3");

    // Case E: configuration register mismatch (R3)
    #1 id_resp = 16'h2828; cfg_resp = 16'h0300;
    push(0, 8'hB0, 0, 2 * RST_T, 1, "R3");
    push(0, 8'hB7, 0, 0, 0, "R3");
    run(0, "R3");

    // Case F: unsupported depth, no reset pulse (R7)
    #1 cfg_resp = 16'h0301; color_bpp = 20;
    run(0, "R7");
    chk(rlow == 0, "R7", "bridge reset low cycles", rlow, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule